// File: doc/BRIEF.md
# Prescaled Period-Match Timer

This block is a 16-bit up-counter driven by a power-of-two division of the system clock. Software programs a 16-bit period, split into two byte registers, and a control byte holding an enable bit and a 3-bit divide select. While enabled, the counter advances once per prescaled tick. When a tick arrives while the count equals the period, the counter reloads to 1 rather than 0, and a one-clock pulse appears on the match output. That output feeds an interrupt flag or a waveform generator downstream.

The count can be read back at any time as a low byte and a high byte. Clearing the enable freezes the count. Setting it again restarts the count at 1 and restarts the divider from zero. Every reset clears the divider, the count, the period and the control byte.

Top module: `permatch_timer`

## Requirements
- R1: After reset the count reads 0, the match output is low and the timer is disabled, so the count stays 0 until enabled.
- R2: Writes are decoded by `wr_addr`: address 0 is control, with bit 0 as enable and bits 3:1 as divide select; address 1 is the period low byte; address 2 is the period high byte. The count is presented as `cnt_lo` (bits 7:0) and `cnt_hi` (bits 15:8).
- R3: Divide select value s produces one prescaled tick every 2^(s+1) clocks: 0 gives 1:2 and 7 gives 1:256. The divider restarts from zero when the timer is enabled.
- R4: In the clock after the edge that sets enable, the count becomes 1. The first increment follows 2^(s+1) clocks after that enabling edge.
- R5: On each tick the count increments by one, unless it equals the period. In that case it reloads to 1, so a period P of 2 or more repeats every P ticks.
- R6: The match output is high for exactly one clock, in the cycle that follows the tick that causes the reload. In that cycle the count reads 1.
- R7: While enable is low, the count holds its value and no match is produced, including when the period is rewritten.
- R8: A period of 0 or 1 yields a match on every tick, and the count stays at 1.
- R9: A period written while the timer runs is used at the next compare without restarting the count.
- R10: A reset asserted mid-run clears the count, the period, the enable and the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period low, 2 period high |
| wr_data | input | 8 | Write data byte |
| cnt_lo | output | 8 | Count bits 7:0 |
| cnt_hi | output | 8 | Count bits 15:8 |
| match_flag | output | 1 | One-clock period-match pulse |

## Verification
The count and match output are compared every clock against a model computed from elapsed clocks, the divide ratio and the period. All eight divide selects are run with a short period, which separates an off-by-one in the ratio from a misordered select decode. A period with a non-zero high byte shows that both bytes reach the compare. Periods of 0 and 1 confirm the every-tick case. Rewriting the period mid-run shows that it takes effect without a restart. Disabling and re-enabling separates holding from clearing, and a reset mid-run followed by enabling with the default period shows that the period and the enable were cleared.

// File: rtl/permatch_pkg.sv
package permatch_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int PS_W   = 1 << SEL_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PLO  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PHI  = 2'd2;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
    } regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en_prev;
        logic             match;
    } cnt_state_t;
endpackage

// File: rtl/permatch_regs.sv
module permatch_regs
    import permatch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                en_o,
    output logic [SEL_W-1:0]    sel_o,
    output logic [CNT_W-1:0]    period_o
);
    regs_t r_d, r_q;
    logic  unused_bits;

    assign unused_bits = ^wr_data[BYTE_W-1:SEL_W+1];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: r_d.ctrl = ctrl_t'(wr_data[SEL_W:0]);
                ADDR_PLO:  r_d.period[BYTE_W-1:0] = wr_data;
                ADDR_PHI:  r_d.period[CNT_W-1:BYTE_W] = wr_data;
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o     = r_q.ctrl.en;
    assign sel_o    = r_q.ctrl.sel;
    assign period_o = r_q.period;

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL) |=> (en_o == $past(wr_data[0]) && sel_o == $past(wr_data[SEL_W:1])));
    assert_plo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_PLO) |=> (period_o[BYTE_W-1:0] == $past(wr_data)));
endmodule

// File: rtl/permatch_presc.sv
module permatch_presc
    import permatch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [PS_W-1:0] ps_d, ps_q;
    logic [PS_W-1:0] mask;

    for (genvar i = 0; i < PS_W; i++) begin : g_mask
        assign mask[i] = (i <= int'(sel_i));
    end

    always_comb begin
        ps_d = ps_q;
        if (!en_i) ps_d = '0;
        else       ps_d = ps_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign tick_o = en_i && ((ps_q & mask) == mask);

    assert_div_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (ps_q == '0));
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/permatch_counter.sv
module permatch_counter
    import permatch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    cnt_state_t s_d, s_q;
    logic       hit;

    assign hit = (period_i <= CNT_W'(1)) || (s_q.cnt == period_i);

    always_comb begin
        s_d         = s_q;
        s_d.en_prev = en_i;
        s_d.match   = 1'b0;
        if (en_i) begin
            if (!s_q.en_prev) begin
                s_d.cnt = CNT_W'(1);
            end else if (tick_i) begin
                if (hit) begin
                    s_d.cnt   = CNT_W'(1);
                    s_d.match = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o   = s_q.cnt;
    assign match_o = s_q.match;

    assert_start_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !s_q.en_prev) |=> (cnt_o == CNT_W'(1)));
    assert_reload_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (cnt_o == CNT_W'(1)));
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(cnt_o) && !match_o));
endmodule

// File: rtl/permatch_timer.sv
module permatch_timer
    import permatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        cnt_lo,
    output logic [7:0]        cnt_hi,
    output logic              match_flag
);
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] period;
    logic             tick;
    logic [CNT_W-1:0] cnt;

    permatch_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .en_o     (en),
        .sel_o    (sel),
        .period_o (period)
    );

    permatch_presc u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .sel_i  (sel),
        .tick_o (tick)
    );

    permatch_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .tick_i   (tick),
        .period_i (period),
        .cnt_o    (cnt),
        .match_o  (match_flag)
    );

    assign cnt_lo = cnt[BYTE_W-1:0];
    assign cnt_hi = cnt[CNT_W-1:BYTE_W];

    assert_match_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_flag |-> $past(en));
endmodule

// File: tb/permatch_timer_test.sv
module permatch_timer_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       match_flag;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    permatch_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .match_flag(match_flag)
    );

    function automatic int count_now();
        return int'({cnt_hi, cnt_lo});
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic write_ctrl(input int sel, input bit en);
        write_reg(2'd0, {4'b0, 3'(sel), en});
    endtask

    task automatic write_period(input int p);
        write_reg(2'd1, p[7:0]);
        write_reg(2'd2, p[15:8]);
    endtask

    // check at k clocks after the enabling edge; caller is 1 ns past that edge
    task automatic sample_expect(input int k, input int n, input int p, input string req);
        int pe, t, ec;
        bit em;
        pe = (p < 1) ? 1 : p;
        t  = k / n;
        ec = 1 + (t % pe);
        em = (k % n == 0) && (t > 0) && (t % pe == 0);
        check(count_now() == ec, req, $sformatf("count k=%0d", k), count_now(), ec);
        check(match_flag == em, req, $sformatf("match k=%0d", k), int'(match_flag), int'(em));
    endtask

    task automatic run_expect(input int k0, input int k1, input int n, input int p, input string req);
        for (int k = k0; k <= k1; k++) begin
            @(posedge clk); #1;
            sample_expect(k, n, p, req);
        end
    endtask

    task automatic t_reset();
        #1;
        check(count_now() == 0, "R1", "count in reset", count_now(), 0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) begin
            @(posedge clk); #1;
            check(count_now() == 0, "R1", "count idle after reset", count_now(), 0);
            check(match_flag == 1'b0, "R1", "match idle after reset", int'(match_flag), 0);
        end
    endtask

    task automatic t_idle_period_write();
        write_period(5);
        repeat (10) begin
            @(posedge clk); #1;
            check(count_now() == 0, "R7", "count while disabled", count_now(), 0);
            check(match_flag == 1'b0, "R7", "match while disabled", int'(match_flag), 0);
        end
    endtask

    task automatic t_wide_period();
        write_period(16'h0102);
        write_ctrl(0, 1'b1);
        check(count_now() == 0, "R4", "count on enabling edge", count_now(), 0);
        run_expect(1, 2 * 258 * 2 + 2, 2, 16'h0102, "R2");
        write_ctrl(0, 1'b0);
    endtask

    task automatic t_sel_sweep();
        write_period(3);
        for (int s = 0; s < 8; s++) begin
            write_ctrl(s, 1'b1);
            run_expect(1, 2 * 3 * (2 << s) + 1, 2 << s, 3, "R3");
            write_ctrl(0, 1'b0);
        end
    endtask

    task automatic t_small_periods();
        for (int p = 0; p < 2; p++) begin
            write_period(p);
            write_ctrl(1, 1'b1);
            run_expect(1, 20, 4, p, "R8");
            write_ctrl(0, 1'b0);
        end
    endtask

    task automatic t_period_change();
        write_period(4);
        write_ctrl(0, 1'b1);
        run_expect(1, 3, 2, 6, "R9");
        write_reg(2'd1, 8'd6);
        sample_expect(4, 2, 6, "R9");
        run_expect(5, 26, 2, 6, "R9");
        write_ctrl(0, 1'b0);
    endtask

    task automatic t_disable_hold();
        write_period(5);
        write_ctrl(1, 1'b1);
        run_expect(1, 9, 4, 5, "R5");
        write_ctrl(1, 1'b0);
        check(count_now() == 3, "R7", "count at disable", count_now(), 3);
        write_period(2);
        repeat (20) begin
            @(posedge clk); #1;
            check(count_now() == 3, "R7", "count held", count_now(), 3);
            check(match_flag == 1'b0, "R7", "no match held", int'(match_flag), 0);
        end
        write_period(5);
        write_ctrl(1, 1'b1);
        check(count_now() == 3, "R4", "count on re-enable edge", count_now(), 3);
        run_expect(1, 41, 4, 5, "R6");
    endtask

    task automatic t_mid_reset();
        write_period(7);
        write_ctrl(2, 1'b1);
        repeat (13) @(posedge clk);
        @(negedge clk) rst_n = 1'b0;
        #1;
        check(count_now() == 0, "R10", "count in reset", count_now(), 0);
        check(match_flag == 1'b0, "R10", "match in reset", int'(match_flag), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (10) begin
            @(posedge clk); #1;
            check(count_now() == 0, "R10", "enable cleared", count_now(), 0);
        end
        write_ctrl(0, 1'b1);
        run_expect(1, 20, 2, 0, "R10");
    endtask

    initial begin
        t_reset();
        t_idle_period_write();
        t_wide_period();
        t_sel_sweep();
        t_small_periods();
        t_period_change();
        t_disable_hold();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule